// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Recognizer

This block sits between a set of active-low interrupt request lines and the sequencer of a processor core. Each line is first brought into the clock domain and qualified for stability. Among the qualified lines the highest-numbered active one sets the current request level. That level is then compared against the 3-bit priority mask held in the core's status register.

The block does not interrupt the core at once. It samples the request only when the core pulses a boundary strobe, which the core raises between instructions or at the end of exception processing. When a sampled request passes the mask test, the block raises a taken flag and presents the accepted level. Both stay frozen until the core acknowledges. The highest level ignores the mask. It is taken once for each new assertion, so a line that stays low cannot trap the core in endless re-entry.

Top module: `irq_level_recognizer`

## Requirements
- R1: While reset is asserted and after it is released, with no boundary strobe, `take_int` is 0 and `int_level` is 0.
- R2: A request counts only after the line has been sampled low on two consecutive rising edges. The earliest boundary strobe that can accept a line driven low just before edge k is the one sampled at edge k+3. A low pulse that lasts for one sample is never accepted.
- R3: When several lines are qualified at once, the accepted level is the highest-numbered active line.
- R4: A request of level 1 to 6 is accepted only if its level is strictly greater than `mask`. Level 0 (no line active) is never accepted.
- R5: A level-7 request is accepted whatever the value of `mask`.
- R6: A level-7 request that stays asserted is accepted once only. It can be accepted again only after the qualified level has dropped below 7 and risen to 7 again.
- R7: A qualified request is acted on only at a rising edge where `boundary` is 1. Without a boundary strobe, `take_int` stays 0.
- R8: Once a request is taken, `take_int` stays 1 and `int_level` holds the accepted level until acknowledge. Boundary strobes and changes in the requests have no effect on them meanwhile.
- R9: `ack` sampled while `take_int` is 1 returns `take_int` and `int_level` to 0 at the next edge. `ack` while idle has no effect.
- R10: No latch is kept. A request that is qualified and then withdrawn before the boundary strobe is not accepted.
- R11: Bit i of `irq_n` requests level i and is active when 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low request lines, bit i is level i (bits 7:1) |
| mask | input | 3 | Current priority mask from the status register |
| boundary | input | 1 | Instruction or exception-end boundary strobe |
| ack | input | 1 | Core acknowledge, releases the taken state |
| take_int | output | 1 | Interrupt accepted and awaiting acknowledge |
| int_level | output | 3 | Accepted level while taken, otherwise 0 |

## Verification
The bench uses the default build: seven levels and a 3-bit mask. This makes the full space small enough to cover completely. All 128 request patterns are swept against all eight mask values, which covers every priority encoding, every mask comparison and the mask bypass of the top level. Directed sequences then probe edge timing around the filter, a one-sample glitch, re-entry of a held level 7, freezing while taken, and withdrawal before the boundary.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_TAKEN = 1'b1
  } rec_state_e;

endpackage

// File: rtl/irq_line_filter.sv
module irq_line_filter #(
  parameter int NUM_LINES = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_raw,
  output logic [NUM_LINES-1:0] req_qual
);

  logic [NUM_LINES-1:0] samp_a_q, samp_b_q, qual_q;
  logic [NUM_LINES-1:0] samp_a_d, samp_b_d, qual_d;
  logic [NUM_LINES-1:0] qual_en;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_comb begin
      samp_a_d[g] = req_raw[g];
      samp_b_d[g] = samp_a_q[g];
      qual_en[g]  = (samp_a_q[g] == samp_b_q[g]);
      qual_d[g]   = qual_en[g] ? samp_b_q[g] : qual_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        samp_a_q[g] <= 1'b0;
        samp_b_q[g] <= 1'b0;
        qual_q[g]   <= 1'b0;
      end else begin
        samp_a_q[g] <= samp_a_d[g];
        samp_b_q[g] <= samp_b_d[g];
        if (qual_en[g]) qual_q[g] <= qual_d[g];
      end
    end

    // R2: the qualified value moves only after two equal samples
    p_qual_needs_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_q[g] != $past(qual_q[g])) |-> ($past(samp_a_q[g]) == $past(samp_b_q[g])));
  end

  assign req_qual = qual_q;

endmodule

// File: rtl/irq_prio_encode.sv
module irq_prio_encode #(
  parameter int NUM_LINES = 7,
  parameter int LVL_W     = $clog2(NUM_LINES + 1)
) (
  input  logic [NUM_LINES-1:0] req,
  output logic [LVL_W-1:0]     level
);

  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i]) level = LVL_W'(i + 1);
    end
  end

  // R3: a nonzero level points at an active line
  always_comb begin
    if (level != '0) begin
      p_level_is_active_r3: assert (req[level - LVL_W'(1)]);
    end
  end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_rec_pkg::*;
#(
  parameter int NUM_LINES = 7,
  parameter int LVL_W     = $clog2(NUM_LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mask,
  input  logic             boundary,
  input  logic             ack,
  output logic             take_int,
  output logic [LVL_W-1:0] int_level
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LINES);

  rec_state_e       state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             lvl_en;
  logic             top_seen_q, top_seen_d;
  logic             armed_q, armed_d;
  logic             is_top, top_fresh, armed_eff;
  logic             eligible, accept, release_ack;

  always_comb begin
    is_top      = (level == TOP_LVL);
    top_fresh   = is_top && !top_seen_q;
    armed_eff   = is_top && (armed_q || top_fresh);
    eligible    = is_top ? armed_eff : ((level != '0) && (level > mask));
    accept      = (state_q == ST_IDLE) && boundary && eligible;
    release_ack = (state_q == ST_TAKEN) && ack;
    top_seen_d  = is_top;
    armed_d     = armed_eff && !accept;

    state_d = state_q;
    lvl_d   = lvl_q;
    lvl_en  = 1'b0;
    if (accept) begin
      state_d = ST_TAKEN;
      lvl_d   = level;
      lvl_en  = 1'b1;
    end else if (release_ack) begin
      state_d = ST_IDLE;
      lvl_d   = '0;
      lvl_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lvl_q      <= '0;
      top_seen_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      top_seen_q <= top_seen_d;
      armed_q    <= armed_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  assign take_int  = (state_q == ST_TAKEN);
  assign int_level = lvl_q;

  // R1: idle output carries no level
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !take_int |-> (int_level == '0));

  // R7: acceptance only follows a boundary strobe
  p_take_needs_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_int) |-> $past(boundary));

  // R4: a maskable level was above the mask when accepted
  p_mask_respected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take_int) && (int_level != TOP_LVL)) |-> ((int_level != '0) && (int_level > $past(mask))));

  // R5: a newly raised top level at an idle boundary is accepted
  p_top_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && boundary && is_top && !top_seen_q) |=> take_int);

  // R8: the accepted level is frozen while taken
  p_level_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_int && $past(take_int)) |-> $stable(int_level));

  // R9: acknowledge releases the taken state
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_int && ack) |=> !take_int);

endmodule

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer #(
  parameter int NUM_LEVELS = 7,
  parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS:1]   irq_n,
  input  logic [LVL_W-1:0]      mask,
  input  logic                  boundary,
  input  logic                  ack,
  output logic                  take_int,
  output logic [LVL_W-1:0]      int_level
);

  logic [NUM_LEVELS-1:0] req_raw;
  logic [NUM_LEVELS-1:0] req_qual;
  logic [LVL_W-1:0]      cur_level;

  assign req_raw = ~irq_n;

  irq_line_filter #(
    .NUM_LINES (NUM_LEVELS)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_raw  (req_raw),
    .req_qual (req_qual)
  );

  irq_prio_encode #(
    .NUM_LINES (NUM_LEVELS),
    .LVL_W     (LVL_W)
  ) u_encode (
    .req   (req_qual),
    .level (cur_level)
  );

  irq_accept_ctrl #(
    .NUM_LINES (NUM_LEVELS),
    .LVL_W     (LVL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (cur_level),
    .mask      (mask),
    .boundary  (boundary),
    .ack       (ack),
    .take_int  (take_int),
    .int_level (int_level)
  );

endmodule

// File: tb/tb_irq_level_recognizer.sv
module tb_irq_level_recognizer;

  logic       clk;
  logic       rst_n;
  logic [7:1] irq_n;
  logic [2:0] mask;
  logic       boundary;
  logic       ack;
  logic       take_int;
  logic [2:0] int_level;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_level_recognizer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n),
    .mask      (mask),
    .boundary  (boundary),
    .ack       (ack),
    .take_int  (take_int),
    .int_level (int_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  task automatic release_all();
    irq_n = '1;
    cyc(4);
  endtask

  // driven at a negedge, qualified, then one boundary strobe
  task automatic strobe_after_qual();
    cyc(3);
    boundary = 1'b1;
    cyc(1);
    boundary = 1'b0;
  endtask

  initial begin
    int i;
    i = 0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_n = '1; mask = '0; boundary = 1'b0; ack = 1'b0;
    cyc(2);
    chk("R1 take in reset", int'(take_int), 0);
    chk("R1 level in reset", int'(int_level), 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 take after reset", int'(take_int), 0);
    chk("R1 level after reset", int'(int_level), 0);

    // R9: ack while idle does nothing
    do_ack();
    chk("R9 ack idle", int'(take_int), 0);

    // R2: earliest acceptance edge
    mask = 3'd0;
    irq_n = ~7'b0010000;       // level 5 (R11 bit 5)
    cyc(2);
    boundary = 1'b1;
    cyc(1);
    chk("R2 too early", int'(take_int), 0);
    cyc(1);
    boundary = 1'b0;
    chk("R2 accepted", int'(take_int), 1);
    chk("R2 level", int'(int_level), 5);
    do_ack();
    chk("R9 cleared", int'(take_int), 0);
    chk("R9 level cleared", int'(int_level), 0);
    release_all();

    // R2: single-sample glitch is filtered
    boundary = 1'b1;
    irq_n = ~7'b0010000;
    cyc(1);
    irq_n = '1;
    cyc(5);
    boundary = 1'b0;
    chk("R2 glitch", int'(take_int), 0);

    // R7: no boundary, no acceptance
    irq_n = ~7'b0000100;       // level 3
    cyc(8);
    chk("R7 no boundary", int'(take_int), 0);
    boundary = 1'b1;
    cyc(1);
    boundary = 1'b0;
    chk("R7 boundary take", int'(take_int), 1);

    // R8: frozen while taken
    irq_n = ~7'b0100000;       // level 6
    cyc(3);
    boundary = 1'b1;
    cyc(2);
    boundary = 1'b0;
    chk("R8 still taken", int'(take_int), 1);
    chk("R8 level held", int'(int_level), 3);
    do_ack();
    chk("R9 ack taken", int'(take_int), 0);
    release_all();

    // R6: held level 7 taken once
    mask = 3'd7;
    irq_n = ~7'b1000100;
    strobe_after_qual();
    chk("R6 first take", int'(take_int), 1);
    chk("R6 level", int'(int_level), 7);
    do_ack();
    mask = 3'd0;
    cyc(1);
    boundary = 1'b1;
    cyc(1);
    boundary = 1'b0;
    chk("R6 held not retaken", int'(take_int), 0);
    irq_n = ~7'b0000100;       // drop 7, keep 3
    cyc(4);
    irq_n = ~7'b1000100;       // reassert 7
    strobe_after_qual();
    chk("R6 retaken", int'(take_int), 1);
    chk("R6 retaken level", int'(int_level), 7);
    do_ack();
    release_all();

    // R10: withdrawn before boundary
    irq_n = ~7'b0001000;       // level 4
    cyc(4);
    irq_n = '1;
    strobe_after_qual();
    chk("R10 withdrawn", int'(take_int), 0);
    release_all();

    // R3 R4 R5 R11: full sweep of patterns and masks
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 128; v++) begin
        int lvl;
        int exp_take;
        lvl = 0;
        for (int b = 0; b < 7; b++) if (v[b]) lvl = b + 1;
        exp_take = (lvl == 7) ? 1 : ((lvl != 0 && lvl > m) ? 1 : 0);
        mask  = 3'(m);
        irq_n = ~7'(v);
        strobe_after_qual();
        if (lvl == 7) chk("R5 top bypass", int'(take_int), exp_take);
        else          chk("R4 mask compare", int'(take_int), exp_take);
        chk("R3 encoded level", int'(int_level), exp_take ? lvl : 0);
        if (take_int) do_ack();
        release_all();
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule